// File: doc/BRIEF.md
# Data Cache Block Maintenance Unit

This block runs line-maintenance commands against a small direct-mapped write-back data cache that it owns. There are four commands. Flush writes a dirty line back and then drops it. Store-back writes a dirty line back and keeps it as a clean copy. Invalidate drops a line and discards its contents, and it needs privilege. Zero-allocate claims the line and clears all of its bytes. A command supplies a base operand, an index operand and a flag that marks the base as the constant zero. The block adds the operands to form the effective address, drops the offset within the 128-byte line, looks the line up, and carries out whatever write-back and state change the command calls for.

A write-back leaves the block as sixteen 64-bit beats on a valid/ready memory write port. While the beats are in flight the block holds `busy`. Commands that need no write-back complete in a single cycle. Two inputs abort a command before it touches anything: a translation fault from the address translator, or a missing privilege level on an invalidate. Each raises its own exception pulse.

A small access port lets the surrounding pipeline see the cache contents. It looks up a word and reports hit, dirty and data combinationally. It can also store a word into a line that is already present. The block writes no destination register and enforces no memory ordering.

Top module: `dcache_maint`

## Requirements
- R1: The effective address is `cmd_base + cmd_index` modulo 2^64. When `cmd_base_zero` is 1, the value zero is used in place of `cmd_base`.
- R2: Address bits 6:0 are ignored for line selection. Bits 9:7 index one of 8 lines and bits 63:10 form the tag, so any address inside a line selects the whole line. On the access port, bits 6:3 pick the 64-bit word.
- R3: Command code 0 (flush) on a dirty hit writes the line back and then invalidates it. The write-back is 16 beats at addresses line base + 8*k for k = 0..15 in ascending order, with beat k carrying word k. A later access to the line misses.
- R4: A flush on a clean hit invalidates the line with no memory traffic, and `done` is high in the cycle after acceptance.
- R5: Command code 1 (store-back) on a dirty hit writes the line back as in R3, then leaves it valid and clean. A store-back on a clean line or a miss completes in one cycle with no memory traffic.
- R6: Command code 2 (invalidate) with `cmd_priv`=1 removes a hit line without any write-back. With `cmd_priv`=0 it pulses `exc_privilege` together with `done` and leaves the cache unchanged.
- R7: Command code 3 (zero-allocate) makes the line valid and dirty with all 16 words zero. On a hit, or when the victim line is clean or invalid, it completes in one cycle. When the victim line is valid and dirty, the victim's data is first written back to the victim's own address.
- R8: A command accepted with `xlate_fault`=1 pulses `exc_unmapped` together with `done`, causes no memory traffic and changes no cache state. `exc_unmapped` and `exc_privilege` are never high together.
- R9: A flush, store-back or privileged invalidate that misses completes with `done` high in the cycle after acceptance and produces no memory traffic.
- R10: During a write-back, `mem_wvalid` holds with a stable address and data until `mem_wready`. `busy` stays high until the last beat (`mem_wlast`) is accepted. In the next cycle `busy` is low and `done` is high for one cycle. A command is accepted only when `cmd_valid` is 1 and `busy` is 0.
- R11: The access port reports `acc_hit`, `acc_dirty` and `acc_rdata` combinationally for `acc_addr`. A store (`acc_we`) to a hit line while idle, with no command offered, writes the word and sets dirty. A store to a missing line is ignored.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 2 | 0 flush, 1 store-back, 2 invalidate, 3 zero-allocate |
| cmd_base | input | 64 | Base operand |
| cmd_index | input | 64 | Index operand |
| cmd_base_zero | input | 1 | Base register number is 0: use literal zero |
| cmd_priv | input | 1 | Privileged mode |
| xlate_fault | input | 1 | Translation fault for the command's page |
| busy | output | 1 | Write-back in progress |
| done | output | 1 | One-cycle completion pulse |
| exc_unmapped | output | 1 | Data-storage exception pulse |
| exc_privilege | output | 1 | Privilege exception pulse |
| mem_wvalid | output | 1 | Write beat valid |
| mem_wready | input | 1 | Write beat accepted |
| mem_waddr | output | 64 | Beat byte address |
| mem_wdata | output | 64 | Beat data |
| mem_wlast | output | 1 | Final beat of the line |
| acc_addr | input | 64 | Access port address |
| acc_we | input | 1 | Access port store strobe |
| acc_wdata | input | 64 | Access port store data |
| acc_hit | output | 1 | Access address is present |
| acc_dirty | output | 1 | Present line is dirty |
| acc_rdata | output | 64 | Addressed word |

## Verification
The bench targets several corner cases.

- **Literal-zero base.** It issues commands with `cmd_base_zero` set and a garbage base value. A design that added the base anyway would miss the line and stay silent on the port.
- **Victim write-back on zero-allocate.** It zero-allocates over a dirty line of the same index. Skipping that write-back, or writing it to the new tag's address, shows up as a missing or misaddressed beat in the scoreboard.
- **Flush versus store-back.** Wrong dirty or valid handling after the write-back shows up at the access port.
- **Blocked commands.** It runs faulting commands and a non-privileged invalidate against dirty lines. A design that acted on these anyway would emit beats or lose the stored words.
- **Stalls and completion.** Write-backs run under a toggling ready signal to catch beats that are dropped or duplicated during stalls, and to catch a `done` pulse that arrives too early.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
    localparam int ADDR_W     = 64;
    localparam int DATA_W     = 64;
    localparam int LINE_BYTES = 128;
    localparam int NUM_LINES  = 8;

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int BEATS  = LINE_BYTES / (DATA_W / 8);
    localparam int BEAT_W = $clog2(BEATS);
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

    typedef logic [ADDR_W-1:0] addr_w_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic [1:0] {
        OP_FLUSH = 2'd0,
        OP_STORE = 2'd1,
        OP_INVAL = 2'd2,
        OP_ZERO  = 2'd3
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WB   = 1'b1
    } state_e;

    typedef struct packed {
        tag_t              tag;
        idx_t              idx;
        beat_t             word;
        logic [BYTE_W-1:0] byte_off;
    } addr_f_t;

    typedef struct packed {
        op_e  op;
        idx_t idx;
        tag_t wb_tag;
        tag_t new_tag;
    } ctx_t;

    function automatic addr_f_t split_addr(addr_w_t a);
        return addr_f_t'(a);
    endfunction

    function automatic addr_w_t beat_addr(tag_t t, idx_t i, beat_t b);
        return {t, i, b, {BYTE_W{1'b0}}};
    endfunction
endpackage

// File: rtl/dcm_agen.sv
module dcm_agen
    import dcm_pkg::*;
(
    input  addr_w_t base,
    input  addr_w_t index,
    input  logic    base_zero,
    output addr_w_t ea,
    output addr_f_t ea_f
);
    addr_w_t base_eff;

    always_comb begin
        base_eff = base_zero ? '0 : base;
        ea       = base_eff + index;
        ea_f     = split_addr(ea);
    end
endmodule

// File: rtl/dcm_tags.sv
module dcm_tags
    import dcm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    // command lookup
    input  idx_t a_idx,
    input  tag_t a_tag,
    output logic a_hit,
    output logic a_valid,
    output logic a_dirty,
    output tag_t a_tag_q,
    // access lookup
    input  idx_t b_idx,
    input  tag_t b_tag,
    output logic b_hit,
    output logic b_dirty,
    // entry rewrite
    input  logic w_en,
    input  idx_t w_idx,
    input  logic w_valid,
    input  logic w_dirty,
    input  tag_t w_tag,
    // dirty mark from a store
    input  logic md_en,
    input  idx_t md_idx
);
    logic [NUM_LINES-1:0] valid_q;
    logic [NUM_LINES-1:0] dirty_q;
    tag_t                 tag_q [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[g] <= 1'b0;
                dirty_q[g] <= 1'b0;
                tag_q[g]   <= '0;
            end else if (w_en && w_idx == idx_t'(g)) begin
                valid_q[g] <= w_valid;
                dirty_q[g] <= w_dirty;
                tag_q[g]   <= w_tag;
            end else if (md_en && md_idx == idx_t'(g)) begin
                dirty_q[g] <= 1'b1;
            end
        end
    end

    always_comb begin
        a_valid = valid_q[a_idx];
        a_dirty = dirty_q[a_idx];
        a_tag_q = tag_q[a_idx];
        a_hit   = a_valid && (a_tag_q == a_tag);
        b_hit   = valid_q[b_idx] && (tag_q[b_idx] == b_tag);
        b_dirty = b_hit && dirty_q[b_idx];
    end
endmodule

// File: rtl/dcm_data.sv
module dcm_data
    import dcm_pkg::*;
(
    input  logic  clk,
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  beat_t wr_word,
    input  word_t wr_data,
    input  logic  zero_en,
    input  idx_t  zero_idx,
    input  idx_t  rd0_idx,
    input  beat_t rd0_word,
    output word_t rd0_data,
    input  idx_t  rd1_idx,
    input  beat_t rd1_word,
    output word_t rd1_data
);
    localparam int WORDS = NUM_LINES * BEATS;

    word_t store_q [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        localparam idx_t  LINE = idx_t'(g / BEATS);
        localparam beat_t WSEL = beat_t'(g % BEATS);
        always_ff @(posedge clk) begin
            if (zero_en && zero_idx == LINE) begin
                store_q[g] <= '0;
            end else if (wr_en && wr_idx == LINE && wr_word == WSEL) begin
                store_q[g] <= wr_data;
            end
        end
    end

    assign rd0_data = store_q[{rd0_idx, rd0_word}];
    assign rd1_data = store_q[{rd1_idx, rd1_word}];
endmodule

// File: rtl/dcm_wbseq.sv
module dcm_wbseq
    import dcm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  active,
    input  logic  wready,
    output beat_t beat,
    output logic  last,
    output logic  fin
);
    beat_t beat_q;
    logic  fire;

    always_comb begin
        fire = active && wready;
        last = active && (beat_q == beat_t'(BEATS - 1));
        fin  = fire && last;
        beat = beat_q;
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            beat_q <= '0;
        end else if (fire) begin
            beat_q <= beat_q + beat_t'(1);
        end
    end
endmodule

// File: rtl/dcache_maint.sv
module dcache_maint
    import dcm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic [63:0] cmd_base,
    input  logic [63:0] cmd_index,
    input  logic        cmd_base_zero,
    input  logic        cmd_priv,
    input  logic        xlate_fault,
    output logic        busy,
    output logic        done,
    output logic        exc_unmapped,
    output logic        exc_privilege,
    output logic        mem_wvalid,
    input  logic        mem_wready,
    output logic [63:0] mem_waddr,
    output logic [63:0] mem_wdata,
    output logic        mem_wlast,
    input  logic [63:0] acc_addr,
    input  logic        acc_we,
    input  logic [63:0] acc_wdata,
    output logic        acc_hit,
    output logic        acc_dirty,
    output logic [63:0] acc_rdata
);
    state_e  state_q, state_d;
    ctx_t    ctx_q, ctx_d;
    logic    done_d, unm_d, prv_d;

    addr_w_t ea;
    addr_f_t ea_f;
    addr_f_t acc_f;
    op_e     op;

    logic    c_hit, c_valid, c_dirty;
    tag_t    c_tag;
    logic    b_hit, b_dirty;

    logic    tw_en, tw_valid, tw_dirty;
    idx_t    tw_idx;
    tag_t    tw_tag;
    logic    zero_en;
    idx_t    zero_idx;
    logic    store_en;

    beat_t   beat;
    logic    wb_last, wb_fin;
    word_t   wb_word;

    assign op    = op_e'(cmd_op);
    assign acc_f = split_addr(acc_addr);
    assign busy  = (state_q == ST_WB);

    dcm_agen u_agen (
        .base      (cmd_base),
        .index     (cmd_index),
        .base_zero (cmd_base_zero),
        .ea        (ea),
        .ea_f      (ea_f)
    );

    dcm_tags u_tags (
        .clk     (clk),
        .rst     (rst),
        .a_idx   (ea_f.idx),
        .a_tag   (ea_f.tag),
        .a_hit   (c_hit),
        .a_valid (c_valid),
        .a_dirty (c_dirty),
        .a_tag_q (c_tag),
        .b_idx   (acc_f.idx),
        .b_tag   (acc_f.tag),
        .b_hit   (b_hit),
        .b_dirty (b_dirty),
        .w_en    (tw_en),
        .w_idx   (tw_idx),
        .w_valid (tw_valid),
        .w_dirty (tw_dirty),
        .w_tag   (tw_tag),
        .md_en   (store_en),
        .md_idx  (acc_f.idx)
    );

    dcm_data u_data (
        .clk      (clk),
        .wr_en    (store_en),
        .wr_idx   (acc_f.idx),
        .wr_word  (acc_f.word),
        .wr_data  (acc_wdata),
        .zero_en  (zero_en),
        .zero_idx (zero_idx),
        .rd0_idx  (ctx_q.idx),
        .rd0_word (beat),
        .rd0_data (wb_word),
        .rd1_idx  (acc_f.idx),
        .rd1_word (acc_f.word),
        .rd1_data (acc_rdata)
    );

    dcm_wbseq u_wbseq (
        .clk    (clk),
        .rst    (rst),
        .active (busy),
        .wready (mem_wready),
        .beat   (beat),
        .last   (wb_last),
        .fin    (wb_fin)
    );

    always_comb begin
        state_d  = state_q;
        ctx_d    = ctx_q;
        done_d   = 1'b0;
        unm_d    = 1'b0;
        prv_d    = 1'b0;
        tw_en    = 1'b0;
        tw_idx   = ea_f.idx;
        tw_valid = 1'b0;
        tw_dirty = 1'b0;
        tw_tag   = ea_f.tag;
        zero_en  = 1'b0;
        zero_idx = ea_f.idx;

        if (state_q == ST_IDLE) begin
            if (cmd_valid) begin
                ctx_d.op      = op;
                ctx_d.idx     = ea_f.idx;
                ctx_d.wb_tag  = c_tag;
                ctx_d.new_tag = ea_f.tag;
                if (xlate_fault) begin
                    unm_d  = 1'b1;
                    done_d = 1'b1;
                end else begin
                    unique case (op)
                        OP_FLUSH: begin
                            if (c_hit && c_dirty) begin
                                state_d = ST_WB;
                            end else begin
                                tw_en  = c_hit;
                                done_d = 1'b1;
                            end
                        end
                        OP_STORE: begin
                            if (c_hit && c_dirty) begin
                                state_d = ST_WB;
                            end else begin
                                done_d = 1'b1;
                            end
                        end
                        OP_INVAL: begin
                            if (!cmd_priv) begin
                                prv_d = 1'b1;
                            end else begin
                                tw_en = c_hit;
                            end
                            done_d = 1'b1;
                        end
                        OP_ZERO: begin
                            if (!c_hit && c_valid && c_dirty) begin
                                state_d = ST_WB;
                            end else begin
                                tw_en    = 1'b1;
                                tw_valid = 1'b1;
                                tw_dirty = 1'b1;
                                zero_en  = 1'b1;
                                done_d   = 1'b1;
                            end
                        end
                        default: done_d = 1'b1;
                    endcase
                end
            end
        end else if (wb_fin) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            tw_en   = 1'b1;
            tw_idx  = ctx_q.idx;
            tw_tag  = ctx_q.wb_tag;
            unique case (ctx_q.op)
                OP_STORE: tw_valid = 1'b1;
                OP_ZERO: begin
                    tw_valid = 1'b1;
                    tw_dirty = 1'b1;
                    tw_tag   = ctx_q.new_tag;
                    zero_en  = 1'b1;
                    zero_idx = ctx_q.idx;
                end
                default: tw_valid = 1'b0;
            endcase
        end
    end

    assign store_en = acc_we && b_hit && (state_q == ST_IDLE) && !cmd_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_IDLE;
            ctx_q         <= '0;
            done          <= 1'b0;
            exc_unmapped  <= 1'b0;
            exc_privilege <= 1'b0;
        end else begin
            state_q       <= state_d;
            ctx_q         <= ctx_d;
            done          <= done_d;
            exc_unmapped  <= unm_d;
            exc_privilege <= prv_d;
        end
    end

    always_comb begin
        mem_wvalid = busy;
        mem_wlast  = wb_last;
        mem_waddr  = beat_addr(ctx_q.wb_tag, ctx_q.idx, beat);
        mem_wdata  = wb_word;
        acc_hit    = b_hit;
        acc_dirty  = b_dirty;
    end
endmodule

// File: rtl/dcm_checker.sv
module dcm_checker (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic [1:0]  cmd_op,
    input logic        cmd_priv,
    input logic        xlate_fault,
    input logic        busy,
    input logic        done,
    input logic        exc_unmapped,
    input logic        exc_privilege,
    input logic        mem_wvalid,
    input logic        mem_wready,
    input logic [63:0] mem_waddr,
    input logic [63:0] mem_wdata,
    input logic        mem_wlast
);
    assert_wb_hold_R10: assert property (@(posedge clk) disable iff (rst)
        mem_wvalid && !mem_wready |=> mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata));

    assert_last_done_R10: assert property (@(posedge clk) disable iff (rst)
        mem_wvalid && mem_wready && mem_wlast |=> done && !busy);

    assert_beat_step_R3: assert property (@(posedge clk) disable iff (rst)
        mem_wvalid && mem_wready && !mem_wlast |=> mem_wvalid && (mem_waddr == $past(mem_waddr) + 64'd8));

    assert_fault_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !busy && xlate_fault |=> exc_unmapped && done && !mem_wvalid);

    assert_priv_block_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !busy && !xlate_fault && cmd_op == 2'd2 && !cmd_priv
        |=> exc_privilege && done && !mem_wvalid);

    assert_exc_excl_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({exc_unmapped, exc_privilege}));

    assert_exc_with_done_R8: assert property (@(posedge clk) disable iff (rst)
        (exc_unmapped || exc_privilege) |-> done && !busy);
endmodule

bind dcache_maint dcm_checker u_dcm_checker (.*);

// File: tb/test_dcache_maint.sv
`timescale 1ns/1ps
module test_dcache_maint;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [63:0] cmd_base = '0;
    logic [63:0] cmd_index = '0;
    logic        cmd_base_zero = 1'b0;
    logic        cmd_priv = 1'b0;
    logic        xlate_fault = 1'b0;
    logic        busy, done, exc_unmapped, exc_privilege;
    logic        mem_wvalid, mem_wlast;
    logic        mem_wready = 1'b1;
    logic [63:0] mem_waddr, mem_wdata;
    logic [63:0] acc_addr = '0;
    logic        acc_we = 1'b0;
    logic [63:0] acc_wdata = '0;
    logic        acc_hit, acc_dirty;
    logic [63:0] acc_rdata;

    always #2.5 clk = ~clk;

    dcache_maint i_dcache_maint (.*);

    typedef struct { logic [63:0] addr; logic [63:0] data; } beat_s;
    beat_s       expq[$];
    logic [63:0] model [logic [63:0]];
    int          checks = 0;
    int          errors = 0;
    int          ready_mode = 0;
    int          rcnt = 0;
    bit          finished = 0;

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #1;
        rcnt++;
        mem_wready = (ready_mode == 0) ? 1'b1 : ((rcnt % 3) != 0);
    end

    // monitor: a handshake seen at the negedge completes at the next posedge
    always @(negedge clk) begin
        if (!rst && mem_wvalid && mem_wready) begin
            if (expq.size() == 0) begin
                chk(0, "R9 unexpected write beat", mem_waddr, 64'd0);
            end else begin
                beat_s e;
                e = expq.pop_front();
                chk(mem_waddr == e.addr, "R3 beat address", mem_waddr, e.addr);
                chk(mem_wdata == e.data, "R3 beat data", mem_wdata, e.data);
            end
        end
    end

    function automatic logic [63:0] pat(logic [63:0] a);
        return (a * 64'h9E37_79B9_7F4A_7C15) ^ 64'h0123_4567_89AB_CDEF;
    endfunction

    function automatic logic [63:0] mval(logic [63:0] a);
        return model.exists(a) ? model[a] : 64'd0;
    endfunction

    task automatic push_line(logic [63:0] la);
        for (int k = 0; k < 16; k++) begin
            beat_s e;
            e.addr = la + 64'(k * 8);
            e.data = mval(e.addr);
            expq.push_back(e);
        end
    endtask

    task automatic issue(logic [1:0] op, logic [63:0] b, logic [63:0] ix, logic bz,
                         logic pv, logic ft);
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_op = op; cmd_base = b; cmd_index = ix;
        cmd_base_zero = bz; cmd_priv = pv; xlate_fault = ft;
        @(posedge clk); #1;
        cmd_valid = 1'b0; xlate_fault = 1'b0;
    endtask

    task automatic wait_done(output int cyc, output bit busy_first,
                             output bit unm, output bit prv);
        cyc = 0;
        busy_first = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) busy_first = busy;
        end while (!done && cyc < 2000);
        unm = exc_unmapped;
        prv = exc_privilege;
    endtask

    task automatic peek(logic [63:0] a);
        acc_addr = a;
        #0.1;
    endtask

    task automatic store(logic [63:0] a, logic [63:0] d);
        @(posedge clk); #1;
        acc_addr = a; acc_wdata = d; acc_we = 1'b1;
        @(posedge clk); #1;
        acc_we = 1'b0;
        model[a] = d;
    endtask

    task automatic zero_model(logic [63:0] la);
        for (int k = 0; k < 16; k++) model[la + 64'(k * 8)] = 64'd0;
    endtask

    task automatic fill_line(logic [63:0] la);
        for (int k = 0; k < 16; k++) store(la + 64'(k * 8), pat(la + 64'(k * 8)));
    endtask

    localparam logic [63:0] LA = 64'h0000_0000_1000_0080;
    localparam logic [63:0] LB = 64'h0000_0002_0000_0100;
    localparam logic [63:0] LC = 64'h0000_0003_0000_0180;
    localparam logic [63:0] LD = 64'h0000_0004_0000_0180;
    localparam logic [63:0] LE = 64'h0000_0000_5000_0200;
    localparam logic [63:0] LF = 64'h0000_0006_0000_0280;

    initial begin
        int cyc; bit bf, unm, prv;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // reset state
        chk(!busy && !done && !mem_wvalid, "R10 reset idle", {61'd0, busy, done, mem_wvalid}, 64'd0);
        peek(LA);
        chk(!acc_hit, "R11 reset miss", acc_hit, 0);

        // zero-allocate into an empty slot: one cycle, no traffic
        issue(2'd3, 64'h1000_0000, 64'h85, 1'b0, 1'b0, 1'b0);
        wait_done(cyc, bf, unm, prv);
        zero_model(LA);
        chk(cyc == 1, "R7 zero empty slot one cycle", cyc, 1);
        peek(LA + 64'h48);
        chk(acc_hit && acc_dirty && acc_rdata == 0, "R7 zero line valid dirty zero",
            {acc_hit, acc_dirty, acc_rdata[61:0]}, 64'hC000_0000_0000_0000);
        peek(LA + 64'h7F);
        chk(acc_hit, "R2 any offset selects line", acc_hit, 1);
        fill_line(LA);
        peek(LA + 64'h28);
        chk(acc_rdata == pat(LA + 64'h28), "R11 store hit writes word", acc_rdata, pat(LA + 64'h28));

        // store-back through the literal-zero base, garbage in base
        push_line(LA);
        issue(2'd1, 64'hDEAD_BEEF_0000_0000, LA + 64'h7F, 1'b1, 1'b0, 1'b0);
        wait_done(cyc, bf, unm, prv);
        chk(bf, "R10 busy during write-back", bf, 1);
        chk(cyc == 17, "R10 done after last beat", cyc, 17);
        chk(expq.size() == 0, "R1 literal-zero base write-back", expq.size(), 0);
        peek(LA);
        chk(acc_hit && !acc_dirty, "R5 store-back keeps clean line", {acc_hit, acc_dirty}, 2'b10);
        @(negedge clk);
        chk(!done && !busy, "R10 done is a single pulse", {done, busy}, 0);

        // store-back of a clean line: no traffic
        issue(2'd1, 64'd0, LA, 1'b1, 1'b0, 1'b0);
        wait_done(cyc, bf, unm, prv);
        chk(cyc == 1 && !bf, "R5 clean store-back one cycle", cyc, 1);

        // flush clean hit
        issue(2'd0, 64'd0, LA + 64'h3, 1'b1, 1'b0, 1'b0);
        wait_done(cyc, bf, unm, prv);
        chk(cyc == 1, "R4 clean flush one cycle", cyc, 1);
        peek(LA);
        chk(!acc_hit, "R4 clean flush removes line", acc_hit, 0);

        // flush dirty hit under a stalling write port
        issue(2'd3, LB, 64'h10, 1'b0, 1'b0, 1'b0);
        wait_done(cyc, bf, unm, prv);
        zero_model(LB);
        fill_line(LB);
        ready_mode = 1;
        push_line(LB);
        issue(2'd0, LB, 64'h40, 1'b0, 1'b0, 1'b0);
        wait_done(cyc, bf, unm, prv);
        chk(cyc > 17 && cyc < 40, "R10 stalled write-back completes", cyc, 25);
        chk(expq.size() == 0, "R3 all flush beats seen", expq.size(), 0);
        peek(LB + 64'h8);
        chk(!acc_hit, "R3 flushed line misses", acc_hit, 0);
        ready_mode = 0;

        // zero-allocate over a dirty victim at the same index
        issue(2'd3, 64'd0, LC, 1'b1, 1'b0, 1'b0);
        wait_done(cyc, bf, unm, prv);
        zero_model(LC);
        fill_line(LC);
        push_line(LC);
        issue(2'd3, 64'd0, LD + 64'h11, 1'b1, 1'b0, 1'b0);
        wait_done(cyc, bf, unm, prv);
        zero_model(LD);
        chk(cyc == 17 && expq.size() == 0, "R7 victim written back", cyc, 17);
        peek(LD + 64'h28);
        chk(acc_hit && acc_dirty && acc_rdata == 0, "R7 new line zeroed after eviction",
            {acc_hit, acc_dirty, acc_rdata[61:0]}, 64'hC000_0000_0000_0000);
        peek(LC);
        chk(!acc_hit, "R7 victim evicted", acc_hit, 0);

        // zero-allocate on a hit clears stored data in one cycle
        store(LD + 64'h28, 64'h5555_AAAA_5555_AAAA);
        issue(2'd3, 64'd0, LD, 1'b1, 1'b0, 1'b0);
        wait_done(cyc, bf, unm, prv);
        zero_model(LD);
        peek(LD + 64'h28);
        chk(cyc == 1 && acc_rdata == 0, "R7 zero on hit clears", acc_rdata, 0);

        // non-privileged invalidate is refused
        store(LD + 64'h30, 64'h1234_5678_9ABC_DEF0);
        issue(2'd2, 64'd0, LD, 1'b1, 1'b0, 1'b0);
        wait_done(cyc, bf, unm, prv);
        chk(cyc == 1 && prv && !unm, "R6 privilege exception", {unm, prv}, 2'b01);
        peek(LD + 64'h30);
        chk(acc_hit && acc_dirty && acc_rdata == 64'h1234_5678_9ABC_DEF0,
            "R6 refused invalidate keeps line", acc_rdata, 64'h1234_5678_9ABC_DEF0);

        // privileged invalidate drops dirty data silently
        issue(2'd2, 64'd0, LD, 1'b1, 1'b1, 1'b0);
        wait_done(cyc, bf, unm, prv);
        chk(cyc == 1 && !prv && !bf, "R6 privileged invalidate one cycle", cyc, 1);
        peek(LD);
        chk(!acc_hit, "R6 invalidated line misses", acc_hit, 0);

        // translation fault on zero-allocate
        issue(2'd3, LE, 64'd0, 1'b0, 1'b0, 1'b1);
        wait_done(cyc, bf, unm, prv);
        chk(cyc == 1 && unm && !prv, "R8 fault exception", {unm, prv}, 2'b10);
        peek(LE);
        chk(!acc_hit, "R8 faulting zero allocates nothing", acc_hit, 0);

        // translation fault on a dirty flush
        issue(2'd3, LE, 64'd0, 1'b0, 1'b0, 1'b0);
        wait_done(cyc, bf, unm, prv);
        zero_model(LE);
        store(LE + 64'h8, 64'hFACE_0000_0000_0001);
        issue(2'd0, LE, 64'd0, 1'b0, 1'b0, 1'b1);
        wait_done(cyc, bf, unm, prv);
        chk(unm && !bf, "R8 faulting flush no write-back", bf, 0);
        peek(LE + 64'h8);
        chk(acc_hit && acc_dirty && acc_rdata == 64'hFACE_0000_0000_0001,
            "R8 faulting flush leaves line", {acc_hit, acc_dirty}, 2'b11);

        // misses
        issue(2'd0, 64'd0, LA, 1'b1, 1'b0, 1'b0);
        wait_done(cyc, bf, unm, prv);
        chk(cyc == 1 && !bf, "R9 flush miss one cycle", cyc, 1);
        issue(2'd1, 64'd0, LB, 1'b1, 1'b0, 1'b0);
        wait_done(cyc, bf, unm, prv);
        chk(cyc == 1 && !bf, "R9 store-back miss one cycle", cyc, 1);

        // store to a missing line is ignored
        store(LA + 64'h10, 64'hBAD0_BAD0_BAD0_BAD0);
        peek(LA + 64'h10);
        chk(!acc_hit, "R11 store miss ignored", acc_hit, 0);

        // address sum carries into the tag
        issue(2'd3, 64'h0000_0005_FFFF_FFFF, 64'h0000_0000_0000_0281, 1'b0, 1'b0, 1'b0);
        wait_done(cyc, bf, unm, prv);
        peek(LF);
        chk(acc_hit, "R1 base plus index with carry", acc_hit, 1);
        peek(LF ^ 64'h0000_0000_0000_0400);
        chk(!acc_hit, "R2 tag bits distinguish lines", acc_hit, 0);

        repeat (3) @(negedge clk);
        chk(expq.size() == 0, "R9 no pending beats", expq.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog expired actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule